// File: doc/BRIEF.md
# Timer Counter Channel with Count-Source and Clear Selection

This block is one counting channel of a general-purpose timer unit. It holds an 8-bit control word that picks three things: where count pulses come from, which edge of that source advances the counter, and what condition returns the counter to zero. Count pulses come either from a free-running divider of the system clock (divide by 1, 4, 16 or 64) or from one of four external clock pins. The pins are synchronised and edge-detected inside the block.

Compare-match and input-capture events for the four general registers arrive as one-cycle strobes from logic outside the channel. The channel turns the strobe named by its clear selection into a counter clear. Two of those registers can be placed in buffer mode, and a strobe from a buffered register never clears the counter. A channel can also follow a sibling's synchronous clear when its sync enable is set.

The channel raises a one-cycle overflow pulse when the counter wraps. It also raises a one-cycle sync-clear pulse whenever one of its own register strobes clears the counter, so that sibling channels can follow it.

Top module: `tmr_chan`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count` is 0, `ovf` and `sync_clr_out` are 0, and the control word is 0. A control word of 0 selects divide-by-1, rising edge and no clearing.
- R2: The control word loads `ctrl_wd` on a clock edge where `ctrl_we` is high and is used from the next cycle on. Changing `ctrl_wd` while `ctrl_we` is low has no effect. The fields are: bits 7:5 clear select, bits 4:3 edge select, bits 2:0 count source.
- R3: Count source 000 (divide by 1) advances `count` on every clock edge, whatever the edge select holds.
- R4: Sources 001, 010 and 011 divide by N = 4, 16 and 64. A 6-bit divider is 0 on the first cycle after reset and steps by one each cycle. Edge select 00 counts on cycles where the divider modulo N equals N/2-1. Edge select 01 counts on cycles where it equals N-1. Edge selects 10 and 11 count on both kinds of cycle.
- R5: Sources 100 to 111 count edges of `ext_clk[0]` to `ext_clk[3]`: rising for edge select 00, falling for 01, both for 1x. Each pin passes through two synchronising flops before edge detection, so a pin change sampled at clock edge k advances `count` at edge k+2.
- R6: Clear select 001, 010, 101 and 110 clear `count` at the next edge when `gr_hit[0]`, `gr_hit[1]`, `gr_hit[2]` or `gr_hit[3]` respectively is high.
- R7: When `buf_mode[0]` is high, `gr_hit[2]` does not clear the counter under select 101. When `buf_mode[1]` is high, `gr_hit[3]` does not clear it under select 110.
- R8: Clear select 011 and 111 clear `count` when both `sync_clr_in` and `sync_en` are high. Select 000 and 100 never clear. Register strobes that the select does not name have no effect.
- R9: When a clear and a count fall in the same cycle, the clear wins and `count` becomes 0.
- R10: A count from 0xFFFF wraps to 0, and `ovf` is high for exactly that one cycle, together with `count` = 0.
- R11: `sync_clr_out` is high for one cycle, together with `count` = 0, after each clear caused by a register strobe. A synchronous clear from a sibling does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Load strobe for the control word |
| ctrl_wd | input | 8 | New control word value |
| ext_clk | input | NPIN (4) | Asynchronous external clock pins |
| gr_hit | input | 4 | Match/capture strobes for registers A, B, C, D (bits 0 to 3) |
| buf_mode | input | 2 | Buffer mode of register C (bit 0) and register D (bit 1) |
| sync_en | input | 1 | Channel takes part in synchronous operation |
| sync_clr_in | input | 1 | Synchronous clear from a sibling channel |
| count | output | CNT_W (16) | Counter value |
| ovf | output | 1 | One-cycle wrap pulse |
| sync_clr_out | output | 1 | One-cycle pulse after a register-strobe clear |

## Verification
Several results have a latency of one clock edge: register-strobe and sibling clears, internal divider counts, `ovf` and `sync_clr_out` all show up right after the rising edge at which their cause is sampled. A control word write takes effect one edge later than that. An external pin change needs three edges before `count` moves. The bench drives every input just after a falling edge. A cycle model in the bench advances at each rising edge from the inputs that edge samples, including its own three-stage pin pipeline and divider phase. The outputs are then compared with that model at the following falling edge, so every check lands exactly in the cycle where the result is due.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int CNT_W = 16;
    localparam int DIV_W = 6;
    localparam int NPIN  = 4;
    localparam int NGR   = 4;

    typedef enum logic [2:0] {
        CLR_OFF      = 3'b000,
        CLR_GRA      = 3'b001,
        CLR_GRB      = 3'b010,
        CLR_PEER     = 3'b011,
        CLR_OFF_ALT  = 3'b100,
        CLR_GRC      = 3'b101,
        CLR_GRD      = 3'b110,
        CLR_PEER_ALT = 3'b111
    } clr_sel_e;

    typedef enum logic [1:0] {
        EDGE_UP      = 2'b00,
        EDGE_DOWN    = 2'b01,
        EDGE_ANY     = 2'b10,
        EDGE_ANY_ALT = 2'b11
    } edge_sel_e;

    typedef enum logic [2:0] {
        SRC_DIV1  = 3'b000,
        SRC_DIV4  = 3'b001,
        SRC_DIV16 = 3'b010,
        SRC_DIV64 = 3'b011,
        SRC_PIN0  = 3'b100,
        SRC_PIN1  = 3'b101,
        SRC_PIN2  = 3'b110,
        SRC_PIN3  = 3'b111
    } src_sel_e;

    // clear select occupies the top bits, count source the bottom bits
    typedef struct packed {
        clr_sel_e  clr;
        edge_sel_e edg;
        src_sel_e  src;
    } tmr_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic edge_pick(edge_sel_e e, edge_ev_t ev);
        case (e)
            EDGE_UP:   return ev.rise;
            EDGE_DOWN: return ev.fall;
            default:   return ev.rise | ev.fall;
        endcase
    endfunction

    function automatic logic src_is_pin(src_sel_e s);
        return s[2];
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int DIV_W = tmr_pkg::DIV_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic [1:0] rate_idx,
    input  edge_sel_e edg,
    output logic      tick
);
    localparam int NRATE = DIV_W / 2;

    logic [DIV_W-1:0] div;
    logic [NRATE:0]   rise_v;
    logic [NRATE:0]   fall_v;
    edge_ev_t         ev_sel;

    always_ff @(posedge clk) begin
        if (rst) div <= '0;
        else     div <= div + DIV_W'(1);
    end

    assign rise_v[0] = 1'b1;
    assign fall_v[0] = 1'b1;

    // rate g divides by 2^(2g); the divided clock is div[2g-1]
    generate
        for (genvar g = 1; g <= NRATE; g++) begin : g_rate
            localparam int W = 2 * g;
            assign rise_v[g] = (div[W-1:0] == {1'b0, {(W-1){1'b1}}});
            assign fall_v[g] = &div[W-1:0];
        end
    endgenerate

    assign ev_sel.rise = rise_v[rate_idx];
    assign ev_sel.fall = fall_v[rate_idx];

    // divide-by-1 ignores the edge setting
    assign tick = (rate_idx == 2'd0) ? 1'b1 : edge_pick(edg, ev_sel);

endmodule

// File: rtl/tmr_pin_edge.sv
`timescale 1ns/1ps
module tmr_pin_edge
    import tmr_pkg::*;
#(
    parameter int NPIN = tmr_pkg::NPIN,
    localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  pins,
    input  logic [IDX_W-1:0] pin_idx,
    input  edge_sel_e        edg,
    output logic             tick
);
    logic [NPIN-1:0] rise_v;
    logic [NPIN-1:0] fall_v;
    edge_ev_t        ev_sel;

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            // sh[0], sh[1]: synchroniser; sh[2]: previous synchronised value
            logic [2:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[1:0], pins[p]};
            end
            assign rise_v[p] =  sh[1] & ~sh[2];
            assign fall_v[p] = ~sh[1] &  sh[2];
        end
    endgenerate

    assign ev_sel.rise = rise_v[pin_idx];
    assign ev_sel.fall = fall_v[pin_idx];
    assign tick        = edge_pick(edg, ev_sel);

endmodule

// File: rtl/tmr_clr_sel.sv
`timescale 1ns/1ps
module tmr_clr_sel
    import tmr_pkg::*;
(
    input  clr_sel_e          sel,
    input  logic [NGR-1:0]    gr_hit,
    input  logic [1:0]        buf_mode,
    input  logic              sync_en,
    input  logic              sync_in,
    output logic              clr_any,
    output logic              clr_by_gr
);
    logic clr_peer;

    always_comb begin
        clr_by_gr = 1'b0;
        clr_peer  = 1'b0;
        case (sel)
            CLR_GRA:                clr_by_gr = gr_hit[0];
            CLR_GRB:                clr_by_gr = gr_hit[1];
            CLR_GRC:                clr_by_gr = gr_hit[2] & ~buf_mode[0];
            CLR_GRD:                clr_by_gr = gr_hit[3] & ~buf_mode[1];
            CLR_PEER, CLR_PEER_ALT: clr_peer  = sync_en & sync_in;
            default:                ;
        endcase
    end

    assign clr_any = clr_by_gr | clr_peer;

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
    parameter int CNT_W = tmr_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             clr_by_gr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             sync_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            ovf      <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            ovf      <= inc & ~clr & (&count);
            sync_out <= clr_by_gr;
            if (clr)      count <= '0;
            else if (inc) count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = tmr_pkg::CNT_W,
    parameter int DIV_W = tmr_pkg::DIV_W,
    parameter int NPIN  = tmr_pkg::NPIN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_we,
    input  logic [7:0]            ctrl_wd,
    input  logic [NPIN-1:0]       ext_clk,
    input  logic [tmr_pkg::NGR-1:0] gr_hit,
    input  logic [1:0]            buf_mode,
    input  logic                  sync_en,
    input  logic                  sync_clr_in,
    output logic [CNT_W-1:0]      count,
    output logic                  ovf,
    output logic                  sync_clr_out
);
    localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;

    tmr_ctrl_t ctrl_q;
    logic      int_tick;
    logic      pin_tick;
    logic      inc;
    logic      clr_any;
    logic      clr_by_gr;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= tmr_ctrl_t'(ctrl_wd);
    end

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .rate_idx (ctrl_q.src[1:0]),
        .edg      (ctrl_q.edg),
        .tick     (int_tick)
    );

    tmr_pin_edge #(.NPIN(NPIN)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .pins    (ext_clk),
        .pin_idx (ctrl_q.src[IDX_W-1:0]),
        .edg     (ctrl_q.edg),
        .tick    (pin_tick)
    );

    tmr_clr_sel u_clr (
        .sel       (ctrl_q.clr),
        .gr_hit    (gr_hit),
        .buf_mode  (buf_mode),
        .sync_en   (sync_en),
        .sync_in   (sync_clr_in),
        .clr_any   (clr_any),
        .clr_by_gr (clr_by_gr)
    );

    assign inc = src_is_pin(ctrl_q.src) ? pin_tick : int_tick;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_any),
        .clr_by_gr (clr_by_gr),
        .inc       (inc),
        .count     (count),
        .ovf       (ovf),
        .sync_out  (sync_clr_out)
    );

endmodule

// File: rtl/tmr_chan_chk.sv
`timescale 1ns/1ps
module tmr_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       clr_sel,
    input logic [3:0]       gr_hit,
    input logic [1:0]       buf_mode,
    input logic             sync_en,
    input logic             sync_clr_in,
    input logic [CNT_W-1:0] count,
    input logic             ovf,
    input logic             sync_clr_out
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (count == '0 && !ovf && !sync_clr_out));  // R1

    AST_CLR_BY_A: assert property (@(posedge clk) disable iff (rst)
        (clr_sel == 3'b001 && gr_hit[0]) |=> (count == '0 && sync_clr_out));  // R6

    AST_CLR_BY_B: assert property (@(posedge clk) disable iff (rst)
        (clr_sel == 3'b010 && gr_hit[1]) |=> (count == '0 && sync_clr_out));  // R6

    AST_CLR_BY_C: assert property (@(posedge clk) disable iff (rst)
        (clr_sel == 3'b101 && gr_hit[2] && !buf_mode[0]) |=> (count == '0 && sync_clr_out));  // R6

    AST_CLR_BY_D: assert property (@(posedge clk) disable iff (rst)
        (clr_sel == 3'b110 && gr_hit[3] && !buf_mode[1]) |=> (count == '0 && sync_clr_out));  // R6

    AST_BUF_C_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (clr_sel == 3'b101 && buf_mode[0]) |=> !sync_clr_out);  // R7

    AST_BUF_D_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (clr_sel == 3'b110 && buf_mode[1]) |=> !sync_clr_out);  // R7

    AST_PEER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_sel[1:0] == 2'b11 && sync_en && sync_clr_in) |=> (count == '0 && !sync_clr_out));  // R8

    AST_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + CNT_W'(1) || count == '0));  // R9

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |-> count == '0);  // R10

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);  // R10

    AST_SYNC_OUT_ZERO: assert property (@(posedge clk) disable iff (rst)
        sync_clr_out |-> count == '0);  // R11

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clr_sel      (ctrl_q.clr),
    .gr_hit       (gr_hit),
    .buf_mode     (buf_mode),
    .sync_en      (sync_en),
    .sync_clr_in  (sync_clr_in),
    .count        (count),
    .ovf          (ovf),
    .sync_clr_out (sync_clr_out)
);

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wd = '0;
    logic [3:0]  ext_clk = '0;
    logic [3:0]  gr_hit = '0;
    logic [1:0]  buf_mode = '0;
    logic        sync_en = 1'b0;
    logic        sync_clr_in = 1'b0;
    logic [15:0] count;
    logic        ovf;
    logic        sync_clr_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tmr_chan u0 (
        .clk          (clk),
        .rst          (rst),
        .ctrl_we      (ctrl_we),
        .ctrl_wd      (ctrl_wd),
        .ext_clk      (ext_clk),
        .gr_hit       (gr_hit),
        .buf_mode     (buf_mode),
        .sync_en      (sync_en),
        .sync_clr_in  (sync_clr_in),
        .count        (count),
        .ovf          (ovf),
        .sync_clr_out (sync_clr_out)
    );

    // ---------------- expected-value model ----------------
    logic [15:0] m_cnt;
    logic [5:0]  m_div;
    logic [3:0]  m_s1, m_s2, m_s3;
    logic [7:0]  m_ctrl;
    logic        m_ovf, m_sclr;
    logic        t_tick, t_reg, t_peer;

    // R4: divide-by-N phase rule
    function automatic logic exp_int_tick(logic [5:0] div, logic [2:0] src, logic [1:0] edg);
        int n, low;
        logic r, f;
        if (src[1:0] == 2'd0) return 1'b1;   // R3
        n   = 1 << (2 * int'(src[1:0]));
        low = int'(div) % n;
        r   = (low == n / 2 - 1);
        f   = (low == n - 1);
        if (edg[1]) return r | f;
        return edg[0] ? f : r;
    endfunction

    // R5: pin edge after synchroniser
    function automatic logic exp_pin_tick(logic [3:0] s2, logic [3:0] s3, logic [2:0] src, logic [1:0] edg);
        logic r, f;
        r = s2[src[1:0]] & ~s3[src[1:0]];
        f = ~s2[src[1:0]] & s3[src[1:0]];
        if (edg[1]) return r | f;
        return edg[0] ? f : r;
    endfunction

    // R6, R7
    function automatic logic exp_reg_clr(logic [2:0] sel, logic [3:0] hit, logic [1:0] bm);
        case (sel)
            3'b001: return hit[0];
            3'b010: return hit[1];
            3'b101: return hit[2] && !bm[0];
            3'b110: return hit[3] && !bm[1];
            default: return 1'b0;
        endcase
    endfunction

    // R8
    function automatic logic exp_peer_clr(logic [2:0] sel, logic en, logic sin);
        return (sel[1:0] == 2'b11) && en && sin;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_div = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
            m_ctrl = '0; m_ovf = 1'b0; m_sclr = 1'b0;
        end else begin
            t_tick = m_ctrl[2] ? exp_pin_tick(m_s2, m_s3, m_ctrl[2:0], m_ctrl[4:3])
                               : exp_int_tick(m_div, m_ctrl[2:0], m_ctrl[4:3]);
            t_reg  = exp_reg_clr(m_ctrl[7:5], gr_hit, buf_mode);
            t_peer = exp_peer_clr(m_ctrl[7:5], sync_en, sync_clr_in);
            m_ovf  = t_tick && !(t_reg || t_peer) && (m_cnt == 16'hFFFF);
            m_sclr = t_reg;
            if (t_reg || t_peer) m_cnt = '0;          // R9
            else if (t_tick)     m_cnt = m_cnt + 16'd1;
            m_div = m_div + 6'd1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
            if (ctrl_we) m_ctrl = ctrl_wd;            // R2
        end
    end

    // ---------------- checks ----------------
    task automatic chk(input string tag);
        total++;
        if (count !== m_cnt) begin
            bad++;
            $display("FAIL %s count actual=%h expected=%h", tag, count, m_cnt);
        end
        total++;
        if (ovf !== m_ovf) begin
            bad++;
            $display("FAIL R10 (%s) ovf actual=%b expected=%b", tag, ovf, m_ovf);
        end
        total++;
        if (sync_clr_out !== m_sclr) begin
            bad++;
            $display("FAIL R11 (%s) sync_clr_out actual=%b expected=%b", tag, sync_clr_out, m_sclr);
        end
    endtask

    task automatic run(input logic [7:0] cv, input int n, input string tag,
                       input int hit_pct, input logic [1:0] bm, input bit rnd_ctrl);
        @(negedge clk);
        chk(tag);
        ctrl_we = 1'b1;
        ctrl_wd = cv;
        gr_hit  = '0;
        buf_mode = bm;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag);
            ctrl_we = 1'b0;
            if (rnd_ctrl) begin
                ctrl_wd = 8'($urandom());
                ctrl_we = ($urandom_range(9) == 0);
            end
            for (int b = 0; b < 4; b++) begin
                gr_hit[b] = (int'($urandom_range(99)) < hit_pct);
                if ($urandom_range(9) < 3) ext_clk[b] = ~ext_clk[b];
            end
            sync_clr_in = (int'($urandom_range(99)) < hit_pct);
            sync_en     = 1'($urandom_range(1));
            buf_mode    = bm;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1");
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R1");
        // R3: divide-by-1 counts each cycle, edge bits ignored
        run(8'b000_00_000, 20, "R3", 0, 2'b00, 1'b0);
        run(8'b000_01_000, 20, "R3", 0, 2'b00, 1'b0);
        run(8'b000_11_000, 20, "R3", 0, 2'b00, 1'b0);
        // R4: internal divide with each edge choice
        for (int s = 1; s < 4; s++)
            for (int e = 0; e < 4; e++)
                run({3'b000, 2'(e), 3'(s)}, 150, "R4", 0, 2'b00, 1'b0);
        // R5: external pins
        for (int s = 4; s < 8; s++)
            for (int e = 0; e < 3; e++)
                run({3'b000, 2'(e), 3'(s)}, 100, "R5", 0, 2'b00, 1'b0);
        // R6: register-strobe clears
        run(8'b001_00_000, 120, "R6", 12, 2'b00, 1'b0);
        run(8'b010_00_001, 120, "R6", 12, 2'b00, 1'b0);
        run(8'b101_00_000, 120, "R6", 12, 2'b00, 1'b0);
        run(8'b110_00_000, 120, "R6", 12, 2'b00, 1'b0);
        // R7: buffer mode blocks C and D clears
        run(8'b101_00_000, 120, "R7", 30, 2'b11, 1'b0);
        run(8'b110_00_000, 120, "R7", 30, 2'b11, 1'b0);
        run(8'b101_00_000, 120, "R7", 30, 2'b10, 1'b0);
        run(8'b110_00_000, 120, "R7", 30, 2'b01, 1'b0);
        // R8: sibling clear and no-clear codes
        run(8'b011_00_000, 150, "R8", 20, 2'b00, 1'b0);
        run(8'b111_00_000, 150, "R8", 20, 2'b00, 1'b0);
        run(8'b000_00_000, 100, "R8", 40, 2'b00, 1'b0);
        run(8'b100_00_000, 100, "R8", 40, 2'b00, 1'b0);
        // R9: clear collides with count often
        run(8'b001_00_000, 100, "R9", 50, 2'b00, 1'b0);
        run(8'b010_10_101, 100, "R9", 50, 2'b00, 1'b0);
        // R2: random control writes, loads only on ctrl_we
        run(8'b000_00_000, 3000, "R2", 5, 2'b01, 1'b1);
        // R10: run through a full wrap
        run(8'b000_00_000, 65600, "R10", 0, 2'b00, 1'b0);
        @(negedge clk);
        chk("R10");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule